// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel Sequencer

This block runs a single DMA channel from a linked list of transfer descriptors kept in memory. When the channel is enabled it reads a four-word descriptor, moves the described block one beat at a time (a read access followed by a write access), and paces the beats with an external trigger. A descriptor can ask for one trigger per beat or one trigger for the whole block. At the end of a block the channel applies the descriptor's end action, records its progress in a write-back area, and then either follows the next-descriptor pointer or parks in a suspended state until software resumes it.

There are three request ports, and the channel uses only one at a time. The descriptor port reads 32-bit words. The data port carries beats of 1, 2 or 4 bytes, right-aligned on a 32-bit bus. The write-back port writes 32-bit words. Each port is valid/ready. A request and its address, size, direction and write data stay unchanged from the cycle valid rises until the cycle in which valid and ready are both high, so the memory side can stall the channel for as long as it needs. A read returns its data, and the data port returns its error flag, in that same handshake cycle.

A descriptor sits at a 4-byte-aligned address as four consecutive words: a control word, the source address, the destination address and the next-descriptor address. The control word is laid out as follows:

- bit 0: valid.
- bits 2:1: beat size (0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes).
- bit 3: advance the source address.
- bit 4: advance the destination address.
- bits 6:5: block-end action (bit 5 raises the block interrupt, bit 6 suspends).
- bit 7: block-trigger mode.
- bits 31:8: beat count.

Top module: `dma_chain_seq`

## Requirements
- R1: A rising edge on `en` while the channel is idle fetches the descriptor at `first_desc`. Its four words are read in order at offsets 0, 4, 8 and 12, and any trigger still pending from before is discarded at that point.
- R2: A descriptor whose valid bit (bit 0) is clear puts the channel in the suspended state with no data access. A `resume` pulse reads the same descriptor again, and the channel suspends again if that descriptor is still invalid.
- R3: Beat size code 0 moves 1 byte, code 1 moves 2 bytes, and codes 2 and 3 move 4 bytes. The write data is the read data with the bytes above the beat size cleared, and bytes beyond the beat are left untouched.
- R4: The source and destination addresses are each, independently, either held fixed or advanced after every beat by the beat size in bytes.
- R5: In beat-trigger mode (bit 7 = 0), each trigger pulse moves exactly one beat.
- R6: In block-trigger mode (bit 7 = 1), a single trigger moves every beat of the block.
- R7: At block end, action bit 5 sets `irq_blk` and action bit 6 suspends the channel. When the channel does not suspend, it fetches the next descriptor at once. When it suspends and the next pointer is nonzero, a resume fetches that next descriptor.
- R8: A block that ends with a next-descriptor address of zero always suspends the channel, whatever its action code. A resume then reads the same descriptor again.
- R9: At block end, and on every abort, the channel writes three words to `wb_base`: the remaining beat count at offset 0, the current source address at offset 4, and the current destination address at offset 8.
- R10: An error response on the data port stops the channel. It returns to idle (neither busy nor suspended), sets `err_flag`, and performs no further access until `en` rises again.
- R11: Clearing `en` during a transfer lets the beat in progress finish both its read and its write, then performs the write-back, then leaves the channel idle.
- R12: A trigger that arrives while an earlier trigger is still unconsumed sets `ovr_flag`. A trigger that arrives in the same cycle the pending one is consumed is kept as the new pending trigger and does not count as an overrun.
- R13: `irq_blk`, `err_flag` and `ovr_flag` are sticky. A one on `clr_blk`, `clr_err` or `clr_ovr` clears the matching flag, but a set in the same cycle wins.
- R14: While a data request waits for ready, valid, address and direction stay stable, and at most one of the three ports requests in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Channel enable; rising edge starts, low aborts |
| resume | input | 1 | Pulse that continues a suspended channel |
| trig | input | 1 | Transfer trigger pulse |
| first_desc | input | AW | Address of the first descriptor |
| wb_base | input | AW | Base address of the write-back record |
| desc_req_valid | output | 1 | Descriptor word read request |
| desc_req_addr | output | AW | Descriptor word address |
| desc_req_ready | input | 1 | Descriptor read accepted, data valid |
| desc_rdata | input | 32 | Descriptor word data |
| mem_valid | output | 1 | Data beat request |
| mem_write | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | AW | Beat byte address |
| mem_size | output | 2 | Beat size code |
| mem_wdata | output | 32 | Right-aligned write data |
| mem_ready | input | 1 | Beat accepted |
| mem_rdata | input | 32 | Right-aligned read data |
| mem_err | input | 1 | Error response, valid with ready |
| wb_valid | output | 1 | Write-back word request |
| wb_addr | output | AW | Write-back word address |
| wb_data | output | 32 | Write-back word data |
| wb_ready | input | 1 | Write-back word accepted |
| clr_blk | input | 1 | Clear `irq_blk` |
| clr_err | input | 1 | Clear `err_flag` |
| clr_ovr | input | 1 | Clear `ovr_flag` |
| busy | output | 1 | Channel is working (neither idle nor suspended) |
| suspended | output | 1 | Channel is suspended |
| irq_blk | output | 1 | Block-complete interrupt flag |
| err_flag | output | 1 | Transfer-error flag |
| ovr_flag | output | 1 | Trigger overrun flag |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is trigger capture and trigger consumption. The bench holds `trig` high for two cycles while the channel waits in beat-trigger mode, so the second trigger coincides with consumption of the first. It then expects two beats to be moved with `ovr_flag` still clear.

The second pair is setting and clearing a flag. With the data port stalled, the bench drives a trigger that overruns in the same cycle as `clr_ovr`, and judges that the flag stays set. A later clear on its own must then drop the flag.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

  localparam int CNT_W   = 24;
  localparam int CNT_LSB = 32 - CNT_W;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FETCH, ST_CHECK, ST_WAIT, ST_RD, ST_WR, ST_WB, ST_BLKEND, ST_SUSP
  } seq_state_e;

  function automatic logic [2:0] beat_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    beat_bytes = 3'd1;
      2'd1:    beat_bytes = 3'd2;
      default: beat_bytes = 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] beat_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    beat_mask = 32'h0000_00FF;
      2'd1:    beat_mask = 32'h0000_FFFF;
      default: beat_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/dmaseq_step.sv
module dmaseq_step #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] cur,
  input  logic [1:0]    size,
  input  logic          inc,
  output logic [AW-1:0] nxt
);
  import dmaseq_pkg::*;

  always_comb begin
    if (inc) nxt = cur + AW'(beat_bytes(size));
    else     nxt = cur;
  end

endmodule

// File: rtl/dmaseq_trig.sv
module dmaseq_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic consume,
  input  logic drop,
  output logic pend,
  output logic ovr_set
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pend <= 1'b0;
    else if (drop) pend <= 1'b0;
    else           pend <= (pend & ~consume) | trig;
  end

  assign ovr_set = trig & pend & ~consume & ~drop;

  assert_consume_needs_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
    consume |-> pend);

  assert_trig_captured_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !drop) |=> pend);

endmodule

// File: rtl/dmaseq_flags.sv
module dmaseq_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr[i]) q[i] <= 1'b0;
    end

    assert_set_wins_R13: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> q[i]);
  end

endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          resume,
  input  logic          trig,
  input  logic [AW-1:0] first_desc,
  input  logic [AW-1:0] wb_base,
  output logic          desc_req_valid,
  output logic [AW-1:0] desc_req_addr,
  input  logic          desc_req_ready,
  input  logic [31:0]   desc_rdata,
  output logic          mem_valid,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ready,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_err,
  output logic          wb_valid,
  output logic [AW-1:0] wb_addr,
  output logic [31:0]   wb_data,
  input  logic          wb_ready,
  input  logic          clr_blk,
  input  logic          clr_err,
  input  logic          clr_ovr,
  output logic          busy,
  output logic          suspended,
  output logic          irq_blk,
  output logic          err_flag,
  output logic          ovr_flag
);
  import dmaseq_pkg::*;

  seq_state_e       st;
  logic [1:0]       idx;
  logic             d_valid, d_sinc, d_dinc, d_blk;
  logic [1:0]       d_size, d_act;
  logic [CNT_W-1:0] d_cnt, cnt;
  logic [AW-1:0]    src, dst, nxt_desc, cur_desc;
  logic [AW-1:0]    src_nxt, dst_nxt;
  logic [31:0]      beat_data;
  logic             en_q, first_beat, wb_to_blk;
  logic             pend, ovr_set, consume, go, need_trig, start;
  logic             blk_set, err_set;
  logic [2:0]       flag_q;

  dmaseq_step #(.AW(AW)) u_src_step (.cur(src), .size(d_size), .inc(d_sinc), .nxt(src_nxt));
  dmaseq_step #(.AW(AW)) u_dst_step (.cur(dst), .size(d_size), .inc(d_dinc), .nxt(dst_nxt));

  assign start     = (st == ST_IDLE) & en & ~en_q;
  assign need_trig = ~d_blk | first_beat;
  assign consume   = (st == ST_WAIT) & en & need_trig & pend;
  assign go        = (st == ST_WAIT) & en & (~need_trig | pend);

  dmaseq_trig u_trig (
    .clk(clk), .rst_n(rst_n), .trig(trig), .consume(consume), .drop(start),
    .pend(pend), .ovr_set(ovr_set)
  );

  assign err_set = mem_valid & mem_ready & mem_err;
  assign blk_set = (st == ST_BLKEND) & d_act[0];

  dmaseq_flags #(.N(3)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .set({ovr_set, err_set, blk_set}),
    .clr({clr_ovr, clr_err, clr_blk}),
    .q(flag_q)
  );
  assign irq_blk  = flag_q[0];
  assign err_flag = flag_q[1];
  assign ovr_flag = flag_q[2];

  // Port drive: one request at a time, decoded from the state.
  assign desc_req_valid = (st == ST_FETCH);
  assign desc_req_addr  = cur_desc + AW'({idx, 2'b00});
  assign mem_valid      = (st == ST_RD) | (st == ST_WR);
  assign mem_write      = (st == ST_WR);
  assign mem_addr       = (st == ST_WR) ? dst : src;
  assign mem_size       = d_size;
  assign mem_wdata      = beat_data;
  assign wb_valid       = (st == ST_WB);
  assign wb_addr        = wb_base + AW'({idx, 2'b00});
  always_comb begin
    case (idx)
      2'd0:    wb_data = 32'(cnt);
      2'd1:    wb_data = 32'(src);
      default: wb_data = 32'(dst);
    endcase
  end
  assign busy      = (st != ST_IDLE) & (st != ST_SUSP);
  assign suspended = (st == ST_SUSP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      idx        <= '0;
      d_valid    <= 1'b0;
      d_sinc     <= 1'b0;
      d_dinc     <= 1'b0;
      d_blk      <= 1'b0;
      d_size     <= '0;
      d_act      <= '0;
      d_cnt      <= '0;
      cnt        <= '0;
      src        <= '0;
      dst        <= '0;
      nxt_desc   <= '0;
      cur_desc   <= '0;
      beat_data  <= '0;
      en_q       <= 1'b0;
      first_beat <= 1'b0;
      wb_to_blk  <= 1'b0;
    end else begin
      en_q <= en;
      if (consume) first_beat <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            cur_desc <= first_desc;
            idx      <= '0;
            st       <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (desc_req_ready) begin
            idx <= idx + 2'd1;
            case (idx)
              2'd0: begin
                d_valid <= desc_rdata[0];
                d_size  <= desc_rdata[2:1];
                d_sinc  <= desc_rdata[3];
                d_dinc  <= desc_rdata[4];
                d_act   <= desc_rdata[6:5];
                d_blk   <= desc_rdata[7];
                d_cnt   <= desc_rdata[31:CNT_LSB];
              end
              2'd1: src <= desc_rdata[AW-1:0];
              2'd2: dst <= desc_rdata[AW-1:0];
              default: begin
                nxt_desc <= desc_rdata[AW-1:0];
                st       <= ST_CHECK;
              end
            endcase
          end
        end
        ST_CHECK: begin
          cnt <= d_cnt;
          if (!en)                    st <= ST_IDLE;
          else if (!d_valid)          st <= ST_SUSP;
          else if (d_cnt == '0) begin
            wb_to_blk <= 1'b1;
            st        <= ST_WB;
          end else begin
            first_beat <= 1'b1;
            st         <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (!en) begin
            wb_to_blk <= 1'b0;
            st        <= ST_WB;
          end else if (go) begin
            st <= ST_RD;
          end
        end
        ST_RD: begin
          if (mem_ready) begin
            if (mem_err) st <= ST_IDLE;
            else begin
              beat_data <= mem_rdata & beat_mask(d_size);
              st        <= ST_WR;
            end
          end
        end
        ST_WR: begin
          if (mem_ready) begin
            if (mem_err) st <= ST_IDLE;
            else begin
              cnt <= cnt - CNT_W'(1);
              src <= src_nxt;
              dst <= dst_nxt;
              if (cnt == CNT_W'(1)) begin
                wb_to_blk <= 1'b1;
                st        <= ST_WB;
              end else if (!en) begin
                wb_to_blk <= 1'b0;
                st        <= ST_WB;
              end else begin
                st <= ST_WAIT;
              end
            end
          end
        end
        ST_WB: begin
          if (wb_ready) begin
            if (idx == 2'd2) begin
              idx <= '0;
              st  <= wb_to_blk ? ST_BLKEND : ST_IDLE;
            end else begin
              idx <= idx + 2'd1;
            end
          end
        end
        ST_BLKEND: begin
          idx <= '0;
          if (nxt_desc != '0) cur_desc <= nxt_desc;
          if (d_act[1] || nxt_desc == '0) st <= ST_SUSP;
          else                            st <= ST_FETCH;
        end
        ST_SUSP: begin
          idx <= '0;
          if (!en)         st <= ST_IDLE;
          else if (resume) st <= ST_FETCH;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_one_port_R14: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({desc_req_valid, mem_valid, wb_valid}));

  assert_hold_request_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));

  assert_error_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && mem_err) |=> (!busy && !suspended && err_flag));

  assert_invalid_suspends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CHECK && en && !d_valid) |=> suspended);

  assert_fixed_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_write && mem_valid && mem_ready && !mem_err && !d_sinc) |=> $stable(src));

  assert_abort_writes_back_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && !en) |=> wb_valid);

endmodule

// File: tb/dma_chain_seq_tb_top.sv
module dma_chain_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, resume = 1'b0, trig = 1'b0;
  logic [31:0] first_desc = '0;
  logic [31:0] wb_base = 32'h380;
  logic        desc_req_valid, mem_valid, mem_write, wb_valid;
  logic [31:0] desc_req_addr, mem_addr, mem_wdata, wb_addr, wb_data;
  logic [31:0] desc_rdata, mem_rdata;
  logic [1:0]  mem_size;
  logic        mem_ready, mem_err;
  logic        clr_blk = 1'b0, clr_err = 1'b0, clr_ovr = 1'b0;
  logic        busy, suspended, irq_blk, err_flag, ovr_flag;
  logic        hold = 1'b0;

  logic [7:0]  mem [0:1023];
  int          n_chk = 0, n_fail = 0;
  int          n_fetch = 0, n_rd = 0, n_wr = 0;

  always #5 clk = ~clk;

  function automatic logic [31:0] rd_word(input logic [31:0] a);
    logic [9:0] i;
    i = a[9:0];
    return {mem[i+10'd3], mem[i+10'd2], mem[i+10'd1], mem[i]};
  endfunction

  assign desc_rdata = rd_word(desc_req_addr);
  assign mem_rdata  = rd_word(mem_addr);
  assign mem_ready  = ~hold;
  assign mem_err    = mem_valid & mem_addr[12];

  always @(posedge clk) begin
    if (desc_req_valid) n_fetch <= n_fetch + 1;
    if (mem_valid && mem_ready && !mem_write) n_rd <= n_rd + 1;
    if (mem_valid && mem_ready && mem_write) begin
      n_wr <= n_wr + 1;
      if (!mem_err) begin
        mem[mem_addr[9:0]] <= mem_wdata[7:0];
        if (mem_size != 2'd0) mem[mem_addr[9:0]+10'd1] <= mem_wdata[15:8];
        if (mem_size[1]) begin
          mem[mem_addr[9:0]+10'd2] <= mem_wdata[23:16];
          mem[mem_addr[9:0]+10'd3] <= mem_wdata[31:24];
        end
      end
    end
    if (wb_valid) begin
      mem[wb_addr[9:0]]       <= wb_data[7:0];
      mem[wb_addr[9:0]+10'd1] <= wb_data[15:8];
      mem[wb_addr[9:0]+10'd2] <= wb_data[23:16];
      mem[wb_addr[9:0]+10'd3] <= wb_data[31:24];
    end
  end

  dma_chain_seq #(.AW(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .resume(resume), .trig(trig),
    .first_desc(first_desc), .wb_base(wb_base),
    .desc_req_valid(desc_req_valid), .desc_req_addr(desc_req_addr),
    .desc_req_ready(1'b1), .desc_rdata(desc_rdata),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .mem_err(mem_err),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data), .wb_ready(1'b1),
    .clr_blk(clr_blk), .clr_err(clr_err), .clr_ovr(clr_ovr),
    .busy(busy), .suspended(suspended), .irq_blk(irq_blk),
    .err_flag(err_flag), .ovr_flag(ovr_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_word(input logic [31:0] a, input logic [31:0] d);
    mem[a[9:0]]       = d[7:0];
    mem[a[9:0]+10'd1] = d[15:8];
    mem[a[9:0]+10'd2] = d[23:16];
    mem[a[9:0]+10'd3] = d[31:24];
  endtask

  function automatic logic [31:0] ctl(input logic v, input logic [1:0] sz, input logic si,
                                      input logic di, input logic [1:0] act, input logic blk,
                                      input logic [23:0] cnt);
    return {cnt, blk, act, di, si, sz, v};
  endfunction

  task automatic put_desc(input logic [31:0] a, input logic [31:0] c, input logic [31:0] s,
                          input logic [31:0] d, input logic [31:0] n);
    wr_word(a, c); wr_word(a + 4, s); wr_word(a + 8, d); wr_word(a + 12, n);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_trig();
    @(negedge clk) trig = 1'b1;
    @(negedge clk) trig = 1'b0;
  endtask

  task automatic pulse_resume();
    @(negedge clk) resume = 1'b1;
    @(negedge clk) resume = 1'b0;
  endtask

  task automatic start(input logic [31:0] d);
    @(negedge clk) en = 1'b0;
    cyc(3);
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    first_desc = d;
    en = 1'b1;
    cyc(10);
  endtask

  task automatic wait_susp();
    for (int i = 0; i < 500 && !suspended; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 reset busy", busy, 0);
    chk("R1 reset suspended", suspended, 0);
    chk("R13 reset flags", {irq_blk, err_flag, ovr_flag}, 0);
    chk("R14 reset requests", {desc_req_valid, mem_valid, wb_valid}, 0);
  endtask

  task automatic t_beat_mode();
    int w0;
    put_desc(32'h000, ctl(1, 0, 1, 1, 0, 0, 4), 32'h100, 32'h200, 32'h0);
    w0 = n_wr;
    start(32'h000);
    chk("R1 four descriptor words", n_fetch, 4);
    pulse_trig(); cyc(15);
    chk("R5 one beat per trigger", n_wr - w0, 1);
    chk("R3 byte beat data", mem[10'h200], mem[10'h100]);
    chk("R3 next byte untouched", mem[10'h201], 8'hEE);
    for (int k = 0; k < 3; k++) begin pulse_trig(); cyc(15); end
    wait_susp();
    chk("R8 null next suspends", suspended, 1);
    chk("R5 four beats", n_wr - w0, 4);
    chk("R4 advancing bytes", {mem[10'h203], mem[10'h202], mem[10'h201]},
        {mem[10'h103], mem[10'h102], mem[10'h101]});
    chk("R4 beyond block untouched", mem[10'h204], 8'hEE);
    chk("R9 wb count", rd_word(32'h380), 0);
    chk("R9 wb src", rd_word(32'h384), 32'h104);
    chk("R9 wb dst", rd_word(32'h388), 32'h204);
  endtask

  task automatic t_block_mode();
    int w0;
    put_desc(32'h040, ctl(1, 1, 1, 0, 1, 1, 3), 32'h110, 32'h240, 32'h060);
    put_desc(32'h060, ctl(1, 2, 1, 1, 0, 1, 2), 32'h120, 32'h260, 32'h0);
    w0 = n_wr;
    start(32'h040);
    pulse_trig(); cyc(40);
    chk("R6 whole block on one trigger", n_wr - w0, 3);
    chk("R7 action 1 sets irq", irq_blk, 1);
    chk("R4 fixed dst keeps last halfword", {mem[10'h241], mem[10'h240]},
        {mem[10'h115], mem[10'h114]});
    chk("R3 halfword beat leaves byte 2", mem[10'h242], 8'hEE);
    @(negedge clk) clr_blk = 1'b1;
    @(negedge clk) clr_blk = 1'b0;
    chk("R13 clear irq", irq_blk, 0);
    cyc(20);
    chk("R6 next block waits for trigger", n_wr - w0, 3);
    pulse_trig();
    wait_susp();
    chk("R3 word beat 0", rd_word(32'h260), rd_word(32'h120));
    chk("R3 word beat 1", rd_word(32'h264), rd_word(32'h124));
    chk("R9 wb src after chain", rd_word(32'h384), 32'h128);
  endtask

  task automatic t_invalid();
    int f0, r0, w0;
    put_desc(32'h080, ctl(0, 0, 1, 1, 0, 1, 1), 32'h130, 32'h280, 32'h0);
    f0 = n_fetch; r0 = n_rd; w0 = n_wr;
    start(32'h080);
    wait_susp();
    chk("R2 invalid suspends", suspended, 1);
    chk("R2 no data access", n_rd - r0, 0);
    pulse_resume(); cyc(20);
    chk("R2 still invalid resuspends", suspended, 1);
    chk("R2 resume refetches", n_fetch - f0, 8);
    wr_word(32'h080, ctl(1, 0, 1, 1, 0, 1, 1));
    pulse_resume(); cyc(10);
    pulse_trig(); cyc(20);
    chk("R2 runs once valid", n_wr - w0, 1);
    chk("R2 byte moved", mem[10'h280], mem[10'h130]);
  endtask

  task automatic t_actions();
    int w0;
    put_desc(32'h0A0, ctl(1, 0, 1, 1, 2, 1, 1), 32'h140, 32'h2A0, 32'h0C0);
    put_desc(32'h0C0, ctl(1, 0, 1, 1, 3, 1, 1), 32'h141, 32'h2A1, 32'h0E0);
    put_desc(32'h0E0, ctl(0, 0, 0, 0, 0, 0, 1), 32'h0, 32'h0, 32'h0);
    w0 = n_wr;
    start(32'h0A0);
    pulse_trig();
    wait_susp();
    chk("R7 action 2 suspends", suspended, 1);
    chk("R7 action 2 no irq", irq_blk, 0);
    chk("R7 one beat", n_wr - w0, 1);
    pulse_resume(); cyc(10);
    pulse_trig(); cyc(30);
    chk("R7 resume runs next descriptor", n_wr - w0, 2);
    chk("R7 action 3 suspends", suspended, 1);
    chk("R7 action 3 irq", irq_blk, 1);
    @(negedge clk) clr_blk = 1'b1;
    @(negedge clk) clr_blk = 1'b0;
  endtask

  task automatic t_abort();
    int w0;
    logic [31:0] a0;
    put_desc(32'h030, ctl(1, 0, 1, 1, 1, 0, 4), 32'h150, 32'h2C0, 32'h0);
    w0 = n_wr;
    start(32'h030);
    pulse_trig(); cyc(15);
    @(negedge clk) hold = 1'b1;
    pulse_trig();
    for (int i = 0; i < 50 && !mem_valid; i++) @(negedge clk);
    a0 = mem_addr;
    cyc(3);
    chk("R14 stalled valid held", mem_valid, 1);
    chk("R14 stalled address held", mem_addr, a0);
    @(negedge clk) en = 1'b0;
    cyc(3);
    hold = 1'b0;
    cyc(20);
    chk("R11 beat in progress finishes", n_wr - w0, 2);
    chk("R11 idle after abort", {busy, suspended}, 0);
    chk("R11 wb remaining count", rd_word(32'h380), 2);
    chk("R11 wb src", rd_word(32'h384), 32'h152);
    chk("R11 wb dst", rd_word(32'h388), 32'h2C2);
    chk("R11 no block irq", irq_blk, 0);
  endtask

  task automatic t_overrun();
    int w0;
    put_desc(32'h0D0, ctl(1, 0, 1, 1, 0, 0, 3), 32'h160, 32'h2D0, 32'h0);
    w0 = n_wr;
    start(32'h0D0);
    @(negedge clk) trig = 1'b1;
    @(negedge clk);
    @(negedge clk) trig = 1'b0;
    cyc(20);
    chk("R12 coincident trigger no overrun", ovr_flag, 0);
    chk("R12 coincident trigger kept", n_wr - w0, 2);
    @(negedge clk) hold = 1'b1;
    pulse_trig(); cyc(3);
    pulse_trig(); cyc(2);
    chk("R12 single pending no overrun", ovr_flag, 0);
    pulse_trig(); cyc(1);
    chk("R12 overrun sets flag", ovr_flag, 1);
    @(negedge clk) begin trig = 1'b1; clr_ovr = 1'b1; end
    @(negedge clk) begin trig = 1'b0; clr_ovr = 1'b0; end
    chk("R13 set wins over clear", ovr_flag, 1);
    @(negedge clk) clr_ovr = 1'b1;
    @(negedge clk) clr_ovr = 1'b0;
    chk("R13 clear drops flag", ovr_flag, 0);
    hold = 1'b0;
    wait_susp();
    chk("R12 block completes", n_wr - w0, 3);
  endtask

  task automatic t_error();
    int r0, w0;
    put_desc(32'h020, ctl(1, 2, 1, 1, 0, 1, 2), 32'h1000, 32'h2E0, 32'h0);
    w0 = n_wr;
    start(32'h020);
    pulse_trig(); cyc(20);
    chk("R10 error flag", err_flag, 1);
    chk("R10 channel idle", {busy, suspended}, 0);
    chk("R10 no write after error", n_wr - w0, 0);
    r0 = n_rd;
    pulse_trig(); cyc(20);
    chk("R10 no access after error", n_rd - r0, 0);
    @(negedge clk) clr_err = 1'b1;
    @(negedge clk) clr_err = 1'b0;
    chk("R13 clear error", err_flag, 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = (i < 10'h200) ? 8'((i * 7) + 3) : 8'hEE;
    cyc(4);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_beat_mode();
    t_block_mode();
    t_invalid();
    t_actions();
    t_abort();
    t_overrun();
    t_error();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule